// File: doc/BRIEF.md
# Four-Channel Serial DAC Host Sequencer

This block sits on the host side of a four-output, 8-bit voltage DAC that listens on a three-wire serial port. It also drives a separate update strobe. A client hands over one request at a time through a valid/ready handshake. A request holds a channel number, a gain-range bit, an 8-bit code and two flags: one defers the update and one commits a batch. The sequencer turns each request into a serial word. It toggles the serial clock, presents data, pulses the word-latch line and, when asked, pulses the update strobe. Every phase is timed by counting system clock cycles.

There are two update styles. In immediate style the update strobe is held low, so the addressed output changes as soon as the word is latched. In deferred style the strobe is held high while several channels are written. The last request of the batch carries the commit flag, and one strobe pulse then moves all four outputs together. Each timing count comes from a parameter. It is raised, where needed, to the minimum that the system clock period (SYS_NS) and the converter's limits allow: a 1 MHz serial clock ceiling, a 50 ns setup gap, and 250 ns minimum pulse widths.

Top module: `dac_host_ctrl`

## Requirements
- R1: After reset dac_sclk=1, dac_load=1, dac_ldac=0, dac_data=0, req_ready=1, busy=0 and done=0.
- R2: Each request produces exactly 11 falling edges of dac_sclk. The bits are sampled on those edges in the order chan[1], chan[0], range, code[7] down to code[0]. Channel value n (0..3) addresses output n.
- R3: Every low phase of dac_sclk, and every high phase between two bits of one word, lasts HALF_EFF = max(HALF_CYC, ceil(500/SYS_NS)) cycles. dac_data changes only while dac_sclk is high.
- R4: dac_load falls exactly HALF_EFF+GAP_EFF cycles after the final falling edge of dac_sclk, where GAP_EFF = max(GAP_CYC, ceil(50/SYS_NS)). It stays low for LOAD_EFF = max(LOAD_CYC, ceil(250/SYS_NS)) cycles, and dac_sclk stays high and steady while dac_load is low.
- R5: With defer=0, dac_ldac is low when dac_load falls. The addressed output takes the new code and range, and the other three outputs keep their values.
- R6: With defer=1 and commit=0, dac_ldac is high when dac_load falls and stays steady while dac_load is low. No output changes.
- R7: With defer=1 and commit=1, dac_ldac falls GAP_EFF cycles after dac_load returns high. It stays low for LDAC_EFF = max(LDAC_CYC, ceil(250/SYS_NS)) cycles and then returns high. All four outputs take their latched values at once, and dac_ldac never falls while dac_load is low.
- R8: req_ready is high only while idle. A request is taken when req_valid and req_ready are both high. busy is high from the next cycle until the sequence ends. done is a one-cycle pulse, and req_ready returns high in the cycle after done.
- R9: With PAD_BYTES=1 each request produces 16 falling edges. The first five bits are 0 and are followed by the 11-bit word of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_chan | input | 2 | Output channel to write |
| req_range | input | 1 | Gain-range bit sent with the code |
| req_code | input | 8 | Output code |
| req_defer | input | 1 | Keep the update strobe high; latch only |
| req_commit | input | 1 | After the latch, pulse the update strobe (only with req_defer) |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| dac_sclk | output | 1 | Serial clock to the converter, idles high |
| dac_data | output | 1 | Serial data to the converter |
| dac_load | output | 1 | Word-latch line, active low |
| dac_ldac | output | 1 | Output-update strobe, active low |

## Verification
Several internal faults show up at the pins. A slip in the bit counter or the shifter changes the number of falling edges or the decoded channel and code, and the receiver model catches this on the very next latch pulse. A fault in the phase counter or the effective-duration selection changes a measured high, low, gap or pulse width. A strobe state held at the wrong value gives one of three results: an output changes while deferred, a batch fails to move on commit, or the strobe falls during the latch pulse. Handshake faults appear within one cycle of acceptance or of done.

// File: rtl/dac_host_pkg.sv
package dac_host_pkg;

    localparam int SEL_W      = 2;
    localparam int CODE_W     = 8;
    localparam int WORD_BITS  = SEL_W + 1 + CODE_W;
    localparam int BYTE_FRAME = 16;

    // converter limits in nanoseconds
    localparam int HALF_NS = 500;
    localparam int GAP_NS  = 50;
    localparam int LOAD_NS = 250;
    localparam int LDAC_NS = 250;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BIT_HI,
        ST_BIT_LO,
        ST_GAP_LOAD,
        ST_LOAD_LO,
        ST_GAP_LDAC,
        ST_LDAC_LO,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       sclk;
        logic       load;
        logic       ldac;
        logic       commit;
    } seq_regs_t;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dac_host_word.sv
module dac_host_word
    import dac_host_pkg::*;
#(
    parameter int NBITS = WORD_BITS
) (
    input  logic [SEL_W-1:0]  chan,
    input  logic              rng,
    input  logic [CODE_W-1:0] code,
    output logic [NBITS-1:0]  frame
);

    logic [WORD_BITS-1:0] word;

    // selector first, then range, then code MSB down
    assign word = {chan, rng, code};

    generate
        if (NBITS > WORD_BITS) begin : g_padded
            assign frame = {{(NBITS - WORD_BITS){1'b0}}, word};
        end else begin : g_bare
            assign frame = word;
        end
    endgenerate

endmodule

// File: rtl/dac_host_pace.sv
module dac_host_pace #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = len - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expire = (cnt_q == '0);

endmodule

// File: rtl/dac_host_shift.sv
module dac_host_shift #(
    parameter int NBITS = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic [NBITS-1:0] frame,
    output logic             bit_out,
    output logic             last
);

    localparam int LW = $clog2(NBITS + 1);

    logic [NBITS-1:0] sh_d, sh_q;
    logic [LW-1:0]    left_d, left_q;

    always_comb begin
        sh_d   = sh_q;
        left_d = left_q;
        if (load) begin
            sh_d   = frame;
            left_d = LW'(NBITS);
        end else if (shift) begin
            sh_d   = {sh_q[NBITS-2:0], 1'b0};
            left_d = left_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            left_q <= '0;
        end else begin
            sh_q   <= sh_d;
            left_q <= left_d;
        end
    end

    assign bit_out = sh_q[NBITS-1];
    assign last    = (left_q == LW'(1));

endmodule

// File: rtl/dac_host_ctrl.sv
module dac_host_ctrl
    import dac_host_pkg::*;
#(
    parameter int SYS_NS    = 8,
    parameter int HALF_CYC  = 63,
    parameter int GAP_CYC   = 7,
    parameter int LOAD_CYC  = 32,
    parameter int LDAC_CYC  = 32,
    parameter int PAD_BYTES = 0,
    parameter int CNT_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SEL_W-1:0]  req_chan,
    input  logic              req_range,
    input  logic [CODE_W-1:0] req_code,
    input  logic              req_defer,
    input  logic              req_commit,
    output logic              busy,
    output logic              done,
    output logic              dac_sclk,
    output logic              dac_data,
    output logic              dac_load,
    output logic              dac_ldac
);

    localparam int NBITS    = (PAD_BYTES != 0) ? BYTE_FRAME : WORD_BITS;
    localparam int HALF_EFF = imax(HALF_CYC, ceil_div(HALF_NS, SYS_NS));
    localparam int GAP_EFF  = imax(GAP_CYC,  ceil_div(GAP_NS,  SYS_NS));
    localparam int LOAD_EFF = imax(LOAD_CYC, ceil_div(LOAD_NS, SYS_NS));
    localparam int LDAC_EFF = imax(LDAC_CYC, ceil_div(LDAC_NS, SYS_NS));

    localparam logic [CNT_W-1:0] HALF_LEN = CNT_W'(HALF_EFF);
    localparam logic [CNT_W-1:0] GAP_LEN  = CNT_W'(GAP_EFF);
    localparam logic [CNT_W-1:0] LOAD_LEN = CNT_W'(LOAD_EFF);
    localparam logic [CNT_W-1:0] LDAC_LEN = CNT_W'(LDAC_EFF);

    seq_regs_t        cur_q, nxt_d;
    logic [NBITS-1:0] frame;
    logic             sh_load, sh_shift, bit_out, last_bit;
    logic             pace_start, expire;
    logic [CNT_W-1:0] pace_len;

    dac_host_word #(.NBITS(NBITS)) u_word (
        .chan  (req_chan),
        .rng   (req_range),
        .code  (req_code),
        .frame (frame)
    );

    dac_host_shift #(.NBITS(NBITS)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sh_load),
        .shift   (sh_shift),
        .frame   (frame),
        .bit_out (bit_out),
        .last    (last_bit)
    );

    dac_host_pace #(.CNT_W(CNT_W)) u_pace (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (pace_start),
        .len    (pace_len),
        .expire (expire)
    );

    always_comb begin
        nxt_d      = cur_q;
        sh_load    = 1'b0;
        sh_shift   = 1'b0;
        pace_start = 1'b0;
        pace_len   = HALF_LEN;
        unique case (cur_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    sh_load      = 1'b1;
                    nxt_d.ldac   = req_defer;
                    nxt_d.commit = req_defer & req_commit;
                    nxt_d.state  = ST_BIT_HI;
                    pace_start   = 1'b1;
                    pace_len     = HALF_LEN;
                end
            end
            ST_BIT_HI: begin
                if (expire) begin
                    nxt_d.sclk  = 1'b0;
                    nxt_d.state = ST_BIT_LO;
                    pace_start  = 1'b1;
                    pace_len    = HALF_LEN;
                end
            end
            ST_BIT_LO: begin
                if (expire) begin
                    nxt_d.sclk = 1'b1;
                    pace_start = 1'b1;
                    if (last_bit) begin
                        nxt_d.state = ST_GAP_LOAD;
                        pace_len    = GAP_LEN;
                    end else begin
                        sh_shift    = 1'b1;
                        nxt_d.state = ST_BIT_HI;
                        pace_len    = HALF_LEN;
                    end
                end
            end
            ST_GAP_LOAD: begin
                if (expire) begin
                    nxt_d.load  = 1'b0;
                    nxt_d.state = ST_LOAD_LO;
                    pace_start  = 1'b1;
                    pace_len    = LOAD_LEN;
                end
            end
            ST_LOAD_LO: begin
                if (expire) begin
                    nxt_d.load = 1'b1;
                    if (cur_q.commit) begin
                        nxt_d.state = ST_GAP_LDAC;
                        pace_start  = 1'b1;
                        pace_len    = GAP_LEN;
                    end else begin
                        nxt_d.state = ST_DONE;
                    end
                end
            end
            ST_GAP_LDAC: begin
                if (expire) begin
                    nxt_d.ldac  = 1'b0;
                    nxt_d.state = ST_LDAC_LO;
                    pace_start  = 1'b1;
                    pace_len    = LDAC_LEN;
                end
            end
            ST_LDAC_LO: begin
                if (expire) begin
                    nxt_d.ldac   = 1'b1;
                    nxt_d.commit = 1'b0;
                    nxt_d.state  = ST_DONE;
                end
            end
            ST_DONE: begin
                nxt_d.state = ST_IDLE;
            end
            default: begin
                nxt_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state  <= ST_IDLE;
            cur_q.sclk   <= 1'b1;
            cur_q.load   <= 1'b1;
            cur_q.ldac   <= 1'b0;
            cur_q.commit <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign req_ready = (cur_q.state == ST_IDLE);
    assign busy      = (cur_q.state != ST_IDLE);
    assign done      = (cur_q.state == ST_DONE);
    assign dac_sclk  = cur_q.sclk;
    assign dac_load  = cur_q.load;
    assign dac_ldac  = cur_q.ldac;
    assign dac_data  = bit_out;

endmodule

// File: rtl/dac_host_checker.sv
module dac_host_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic busy,
    input logic done,
    input logic dac_sclk,
    input logic dac_data,
    input logic dac_load,
    input logic dac_ldac
);

    assert_data_moves_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_data) |-> dac_sclk);

    assert_clk_quiet_in_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_load |-> (dac_sclk && $stable(dac_sclk)));

    assert_ldac_steady_in_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_load |-> $stable(dac_ldac));

    assert_ldac_after_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_ldac) |-> (dac_load && $past(dac_load)));

    assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (busy && !req_ready));

    assert_done_then_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (req_ready && !done));

    assert_idle_pins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (dac_load && dac_sclk));

endmodule

bind dac_host_ctrl dac_host_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .busy      (busy),
    .done      (done),
    .dac_sclk  (dac_sclk),
    .dac_data  (dac_data),
    .dac_load  (dac_load),
    .dac_ldac  (dac_ldac)
);

// File: tb/dac_host_ctrl_test.sv
module dac_rx_model (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk,
    input  logic            data,
    input  logic            load,
    input  logic            ldac,
    output logic [3:0][7:0] out_code,
    output logic [3:0]      out_rng,
    output logic [15:0]     last_bits,
    output logic            load_ldac,
    output int              bits_seen,
    output int              fall_to_load,
    output int              load_len,
    output int              ldac_gap,
    output int              ldac_len,
    output int              min_hi,
    output int              min_lo,
    output int              max_lo,
    output int              bad_data
);
    logic [3:0][7:0] lat_code;
    logic [3:0]      lat_rng;
    logic [15:0]     sr;
    logic [1:0]      ch;
    logic            p_sclk, p_data, p_load, p_ldac;
    int              cnt, run, since_fall, since_rise, lo_load, lo_ldac;

    initial begin
        out_code = '0; out_rng = '0; lat_code = '0; lat_rng = '0;
        sr = '0; last_bits = '0; load_ldac = 1'b0;
        bits_seen = 0; fall_to_load = 0; load_len = 0; ldac_gap = 0; ldac_len = 0;
        min_hi = 1000000; min_lo = 1000000; max_lo = 0; bad_data = 0;
        p_sclk = 1'b1; p_data = 1'b0; p_load = 1'b1; p_ldac = 1'b0;
        cnt = 0; run = 0; since_fall = 0; since_rise = 0; lo_load = 0; lo_ldac = 0;
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            p_sclk = 1'b1; p_data = 1'b0; p_load = 1'b1; p_ldac = 1'b0;
            cnt = 0; run = 0;
        end else begin
            since_fall++;
            since_rise++;
            if (sclk != p_sclk) begin
                if (p_sclk) begin
                    if (run < min_hi) min_hi = run;
                end else begin
                    if (run < min_lo) min_lo = run;
                    if (run > max_lo) max_lo = run;
                end
                run = 1;
            end else begin
                run++;
            end
            if (p_sclk && !sclk) begin
                sr = {sr[14:0], data};
                cnt++;
                since_fall = 0;
            end
            if ((data != p_data) && !sclk) bad_data++;
            if (p_load && !load) begin
                fall_to_load = since_fall;
                bits_seen    = cnt;
                cnt          = 0;
                last_bits    = sr;
                load_ldac    = ldac;
                ch           = sr[10:9];
                lat_code[ch] = sr[7:0];
                lat_rng[ch]  = sr[8];
                if (!ldac) begin
                    out_code[ch] = sr[7:0];
                    out_rng[ch]  = sr[8];
                end
                lo_load = 0;
            end
            if (!load) lo_load++;
            if (!p_load && load) begin
                load_len   = lo_load;
                since_rise = 0;
            end
            if (p_ldac && !ldac) begin
                ldac_gap = since_rise;
                out_code = lat_code;
                out_rng  = lat_rng;
                lo_ldac  = 0;
            end
            if (!ldac) lo_ldac++;
            if (!p_ldac && ldac) ldac_len = lo_ldac;
            p_sclk = sclk; p_data = data; p_load = load; p_ldac = ldac;
        end
    end
endmodule

module dac_host_ctrl_test;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n, req_valid, req_valid_p, req_range, req_defer, req_commit;
    logic [1:0] req_chan;
    logic [7:0] req_code;
    logic       req_ready, busy, done, dac_sclk, dac_data, dac_load, dac_ldac;
    logic       ready_p, busy_p, done_p, sclk_p, data_p, load_p, ldac_p;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [7:0] e_code [4];
    logic       e_rng  [4];
    logic [7:0] l_code [4];
    logic       l_rng  [4];

    // bench configuration: SYS_NS=250 gives HALF_EFF=2 (HALF_CYC=1 clamped), GAP 1, LOAD 1, LDAC 2
    dac_host_ctrl #(.SYS_NS(250), .HALF_CYC(1), .GAP_CYC(1), .LOAD_CYC(1), .LDAC_CYC(2), .PAD_BYTES(0)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_chan(req_chan), .req_range(req_range), .req_code(req_code),
        .req_defer(req_defer), .req_commit(req_commit), .busy(busy), .done(done),
        .dac_sclk(dac_sclk), .dac_data(dac_data), .dac_load(dac_load), .dac_ldac(dac_ldac));

    dac_host_ctrl #(.SYS_NS(250), .HALF_CYC(1), .GAP_CYC(1), .LOAD_CYC(1), .LDAC_CYC(2), .PAD_BYTES(1)) uut_pad (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid_p), .req_ready(ready_p),
        .req_chan(req_chan), .req_range(req_range), .req_code(req_code),
        .req_defer(req_defer), .req_commit(req_commit), .busy(busy_p), .done(done_p),
        .dac_sclk(sclk_p), .dac_data(data_p), .dac_load(load_p), .dac_ldac(ldac_p));

    logic [3:0][7:0] rx_code, rxp_code;
    logic [3:0]      rx_rng, rxp_rng;
    logic [15:0]     rx_bits, rxp_bits;
    logic            rx_lldac, rxp_lldac;
    int rx_n, rx_f2l, rx_llen, rx_dgap, rx_dlen, rx_mhi, rx_mlo, rx_xlo, rx_bad;
    int rxp_n, rxp_f2l, rxp_llen, rxp_dgap, rxp_dlen, rxp_mhi, rxp_mlo, rxp_xlo, rxp_bad;

    dac_rx_model rx (.clk(clk), .rst_n(rst_n), .sclk(dac_sclk), .data(dac_data), .load(dac_load), .ldac(dac_ldac),
        .out_code(rx_code), .out_rng(rx_rng), .last_bits(rx_bits), .load_ldac(rx_lldac),
        .bits_seen(rx_n), .fall_to_load(rx_f2l), .load_len(rx_llen), .ldac_gap(rx_dgap), .ldac_len(rx_dlen),
        .min_hi(rx_mhi), .min_lo(rx_mlo), .max_lo(rx_xlo), .bad_data(rx_bad));

    dac_rx_model rx_pad (.clk(clk), .rst_n(rst_n), .sclk(sclk_p), .data(data_p), .load(load_p), .ldac(ldac_p),
        .out_code(rxp_code), .out_rng(rxp_rng), .last_bits(rxp_bits), .load_ldac(rxp_lldac),
        .bits_seen(rxp_n), .fall_to_load(rxp_f2l), .load_len(rxp_llen), .ldac_gap(rxp_dgap), .ldac_len(rxp_dlen),
        .min_hi(rxp_mhi), .min_lo(rxp_mlo), .max_lo(rxp_xlo), .bad_data(rxp_bad));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic send(input bit pad, input logic [1:0] ch, input logic rng,
                        input logic [7:0] code, input logic defer, input logic commit);
        @(negedge clk);
        req_chan = ch; req_range = rng; req_code = code; req_defer = defer; req_commit = commit;
        while (!(pad ? ready_p : req_ready)) @(negedge clk);
        if (pad) req_valid_p = 1'b1; else req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_valid_p = 1'b0;
        check((pad ? busy_p : busy) == 1'b1, "R8 busy after accept", int'(pad ? busy_p : busy), 1);
        check((pad ? ready_p : req_ready) == 1'b0, "R8 ready low while busy", int'(pad ? ready_p : req_ready), 0);
        while (!(pad ? done_p : done)) @(negedge clk);
        @(negedge clk);
        check((pad ? ready_p : req_ready) == 1'b1, "R8 ready after done", int'(pad ? ready_p : req_ready), 1);
        check((pad ? done_p : done) == 1'b0, "R8 done one cycle", int'(pad ? done_p : done), 0);
    endtask

    task automatic check_outputs(input string tag);
        for (int i = 0; i < 4; i++) begin
            check(rx_code[i] == e_code[i], tag, int'(rx_code[i]), int'(e_code[i]));
            check(rx_rng[i] == e_rng[i], tag, int'(rx_rng[i]), int'(e_rng[i]));
        end
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_valid_p = 1'b0;
        req_chan = '0; req_range = 1'b0; req_code = '0; req_defer = 1'b0; req_commit = 1'b0;
        for (int i = 0; i < 4; i++) begin
            e_code[i] = '0; e_rng[i] = 1'b0; l_code[i] = '0; l_rng[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(dac_sclk == 1'b1, "R1 sclk", int'(dac_sclk), 1);
        check(dac_load == 1'b1, "R1 load", int'(dac_load), 1);
        check(dac_ldac == 1'b0, "R1 ldac", int'(dac_ldac), 0);
        check(dac_data == 1'b0, "R1 data", int'(dac_data), 0);
        check(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        check(busy == 1'b0, "R1 busy", int'(busy), 0);
        check(done == 1'b0, "R1 done", int'(done), 0);

        // immediate sweep: every code on every channel, range alternating
        for (int c = 0; c < 256; c++) begin
            for (int ch = 0; ch < 4; ch++) begin
                logic rng;
                rng = logic'((c + ch) & 1);
                send(1'b0, 2'(ch), rng, 8'(c), 1'b0, 1'b0);
                e_code[ch] = 8'(c); e_rng[ch] = rng;
                l_code[ch] = 8'(c); l_rng[ch] = rng;
                check(rx_n == 11, "R2 falling edge count", rx_n, 11);
                check(rx_bits[10:0] == {2'(ch), rng, 8'(c)}, "R2 bit order",
                      int'(rx_bits[10:0]), int'({2'(ch), rng, 8'(c)}));
                check(rx_f2l == 3, "R4 last edge to load", rx_f2l, 3);
                check(rx_llen == 1, "R4 load width", rx_llen, 1);
                check(rx_lldac == 1'b0, "R5 ldac low at load", int'(rx_lldac), 0);
                check_outputs("R5 immediate outputs");
            end
        end

        // R3 phase lengths clamped to 2 and data moves only while high
        check(rx_mlo == 2, "R3 min low phase", rx_mlo, 2);
        check(rx_xlo == 2, "R3 max low phase", rx_xlo, 2);
        check(rx_mhi == 2, "R3 min high phase", rx_mhi, 2);
        check(rx_bad == 0, "R3 data change while low", rx_bad, 0);

        // deferred batches ending with commit
        for (int r = 0; r < 3; r++) begin
            int nch;
            nch = (r == 2) ? 2 : 4;
            for (int k = 0; k < nch; k++) begin
                int ch;
                logic [7:0] code;
                logic rng;
                bit com;
                ch   = (r == 2) ? k + 1 : k;
                code = 8'((37 * r + 61 * k + 5) & 255);
                rng  = logic'((r ^ k) & 1);
                com  = (k == nch - 1);
                send(1'b0, 2'(ch), rng, code, 1'b1, com);
                l_code[ch] = code; l_rng[ch] = rng;
                check(rx_lldac == 1'b1, "R6 ldac high at load", int'(rx_lldac), 1);
                if (!com) begin
                    check_outputs("R6 deferred outputs held");
                end else begin
                    for (int i = 0; i < 4; i++) begin
                        e_code[i] = l_code[i]; e_rng[i] = l_rng[i];
                    end
                    check_outputs("R7 commit outputs");
                    check(rx_dgap == 1, "R7 load rise to ldac fall", rx_dgap, 1);
                    check(rx_dlen == 2, "R7 ldac width", rx_dlen, 2);
                    check(dac_ldac == 1'b1, "R7 ldac back high", int'(dac_ldac), 1);
                end
            end
        end

        // R9 byte-padded frame on the second instance
        for (int k = 0; k < 8; k++) begin
            logic [7:0] code;
            code = 8'((29 * k + 200) & 255);
            send(1'b1, 2'(k & 3), logic'(k >> 2), code, 1'b0, 1'b0);
            check(rxp_n == 16, "R9 padded edge count", rxp_n, 16);
            check(rxp_bits[15:11] == 5'b0, "R9 leading zeros", int'(rxp_bits[15:11]), 0);
            check(rxp_code[k & 3] == code, "R9 padded code", int'(rxp_code[k & 3]), int'(code));
            check(rxp_rng[k & 3] == logic'(k >> 2), "R9 padded range", int'(rxp_rng[k & 3]), k >> 2);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule